// File: doc/BRIEF.md
# OFDM Transmit Frame Assembler

This block produces one complete OFDM transmit frame as a stream of complex 16-bit samples. A single start pulse launches the frame. The block then plays out its stored training sections. First comes a short training section, built from a 16-sample period that is repeated ten times. Next comes a long training section: a 32-sample guard made from the tail of the 64-sample long symbol, then two full copies of that symbol. Two data symbols follow. Each one arrives from an upstream IFFT over a ready/valid input and is held in a 64-entry buffer. Holding it there lets the 16-sample guard, taken from the symbol's tail, go out ahead of the symbol body.

The output is a valid/ready stream with a last flag on the frame's final sample. When the oversampling input is high at start, every sample is sent twice in a row, so the frame grows from 480 to 960 samples. Backpressure on the output freezes the sequencer in place. The preamble contents are parameters of the top module. Each is a packed vector of 64 entries: entry k sits at bits [32k+31:32k], with I in the upper 16 bits and Q in the lower 16 bits.

Top module: `ofdm_frame_asm`

## Requirements
- R1: After reset, outValid, outLast and inReady are all low until a start pulse is seen.
- R2: The first 160 samples of a frame are short-preamble entry (n mod 16) for n = 0..159, where entry k is the k-th 32-bit field of SHORT_ROM (I upper, Q lower).
- R3: Samples 160..191 are long-preamble entries 32..63, and samples 192..319 are long entries 0..63 given twice.
- R4: Each data symbol takes 80 samples. These are its buffered inputs 48..63 followed by its inputs 0..63. The first 64 accepted input samples form symbol 1 and the next 64 form symbol 2.
- R5: A frame has exactly 480 output handshakes. outLast is high on the last of them only, and the block is idle afterwards.
- R6: If osEn is high in the cycle that start is accepted, each sample is presented for two consecutive handshakes, the frame is 960 handshakes long, and outLast marks the second copy of the final sample.
- R7: While outValid is high and outReady is low, outValid, outI, outQ and outLast hold their values into the next cycle. No sample is lost or repeated.
- R8: A start pulse that arrives while a frame is in progress is ignored. The running frame keeps its length and content, and no new frame follows it.
- R9: inReady is high only while a frame is running and the data buffer holds fewer than 64 samples. When a data section is reached with the buffer not yet full, outValid stays low until the buffer fills.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Frame launch pulse |
| osEn | input | 1 | Two-times sample repetition, captured at start |
| inValid | input | 1 | Data-symbol sample valid |
| inReady | output | 1 | Data buffer can take a sample |
| inI | input | 16 | Data sample, in-phase |
| inQ | input | 16 | Data sample, quadrature |
| outValid | output | 1 | Output sample valid |
| outReady | input | 1 | Downstream accepts the sample |
| outI | output | 16 | Output sample, in-phase |
| outQ | output | 16 | Output sample, quadrature |
| outLast | output | 1 | Final sample of the frame |

## Verification
The hardest case to reach from the ports is the output pausing at the edge of the data section because the buffer is still filling. It needs the output to be drained fast while the input is held back. One frame therefore runs with the output always ready and withholds all data samples for the first 400 cycles. At sample 320, outValid must then be low. Other frames mix random output readiness with random input gaps, and they fire a stray start pulse mid-frame. This drives stall and resume at every section boundary, including stalls between the two copies of an oversampled sample.

// File: rtl/ofdm_asm_pkg.sv
package ofdm_asm_pkg;
  parameter int IQ_W = 16;
  localparam int SAMP_W = 2 * IQ_W;
  localparam int ROM_DEPTH = 64;
  localparam int ROM_W = ROM_DEPTH * SAMP_W;
  localparam int ADDR_W = 8;
  localparam int CNT_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SHORT, ST_LCP, ST_LBODY, ST_PCP, ST_PBODY
  } asmState_e;

  typedef enum logic [1:0] {SRC_SHORT, SRC_LONG, SRC_PAY} srcSel_e;

  typedef struct packed {
    srcSel_e             src;
    logic [ADDR_W-1:0]   addr;
    logic                frameOn;
    logic                frameStart;
    logic                bufRelease;
  } asmStrobe_t;

  function automatic logic [ROM_W-1:0] romPattern(input int seed);
    logic [ROM_W-1:0] v;
    v = '0;
    for (int k = 0; k < ROM_DEPTH; k++) begin
      v[k*SAMP_W +: SAMP_W] = {IQ_W'((k + 1) * seed * 577), IQ_W'(seed * 4099 - k * 263)};
    end
    return v;
  endfunction
endpackage

// File: rtl/frame_ctrl.sv
module frame_ctrl
  import ofdm_asm_pkg::*;
#(
  parameter int SHORT_LEN   = 16,
  parameter int SHORT_REPS  = 10,
  parameter int LONG_LEN    = 64,
  parameter int LONG_CP     = 32,
  parameter int LONG_COPIES = 2,
  parameter int SYM_LEN     = 64,
  parameter int SYM_CP      = 16,
  parameter int NUM_SYMS    = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       osEn,
  input  logic       bufFull,
  input  logic       outReady,
  output asmStrobe_t strobe,
  output logic       outValid,
  output logic       outLast
);
  asmState_e         state, nextState;
  logic [ADDR_W-1:0] idx;
  logic [CNT_W-1:0]  rep, sym;
  logic              phase, osMode;
  logic              idxEnd, fire, sampDone, blockEnd;
  logic [CNT_W-1:0]  repLim;

  always_comb begin
    strobe.src  = SRC_SHORT;
    strobe.addr = idx;
    idxEnd      = 1'b0;
    repLim      = '0;
    nextState   = state;
    unique case (state)
      ST_SHORT: begin
        idxEnd    = (idx == ADDR_W'(SHORT_LEN - 1));
        repLim    = CNT_W'(SHORT_REPS - 1);
        nextState = ST_LCP;
      end
      ST_LCP: begin
        strobe.src  = SRC_LONG;
        strobe.addr = idx + ADDR_W'(LONG_LEN - LONG_CP);
        idxEnd      = (idx == ADDR_W'(LONG_CP - 1));
        nextState   = ST_LBODY;
      end
      ST_LBODY: begin
        strobe.src = SRC_LONG;
        idxEnd     = (idx == ADDR_W'(LONG_LEN - 1));
        repLim     = CNT_W'(LONG_COPIES - 1);
        nextState  = ST_PCP;
      end
      ST_PCP: begin
        strobe.src  = SRC_PAY;
        strobe.addr = idx + ADDR_W'(SYM_LEN - SYM_CP);
        idxEnd      = (idx == ADDR_W'(SYM_CP - 1));
        nextState   = ST_PBODY;
      end
      ST_PBODY: begin
        strobe.src = SRC_PAY;
        idxEnd     = (idx == ADDR_W'(SYM_LEN - 1));
        nextState  = (sym == CNT_W'(NUM_SYMS - 1)) ? ST_IDLE : ST_PCP;
      end
      default: ;
    endcase
  end

  assign outValid  = (state != ST_IDLE) && ((strobe.src != SRC_PAY) || bufFull);
  assign fire      = outValid && outReady;
  assign sampDone  = fire && (!osMode || phase);
  assign blockEnd  = sampDone && idxEnd && (rep == repLim);
  assign outLast   = outValid && (state == ST_PBODY) && idxEnd &&
                     (sym == CNT_W'(NUM_SYMS - 1)) && (!osMode || phase);

  assign strobe.frameOn    = (state != ST_IDLE);
  assign strobe.frameStart = (state == ST_IDLE) && start;
  assign strobe.bufRelease = blockEnd && (state == ST_PBODY);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      idx    <= '0;
      rep    <= '0;
      sym    <= '0;
      phase  <= 1'b0;
      osMode <= 1'b0;
    end else if (state == ST_IDLE) begin
      if (start) begin
        state  <= ST_SHORT;
        idx    <= '0;
        rep    <= '0;
        sym    <= '0;
        phase  <= 1'b0;
        osMode <= osEn;
      end
    end else begin
      if (fire) phase <= osMode ? ~phase : 1'b0;
      if (sampDone) begin
        if (!idxEnd) begin
          idx <= idx + 1'b1;
        end else begin
          idx <= '0;
          if (rep != repLim) begin
            rep <= rep + 1'b1;
          end else begin
            rep   <= '0;
            state <= nextState;
            if (state == ST_PBODY) sym <= sym + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/frame_dpath.sv
module frame_dpath
  import ofdm_asm_pkg::*;
#(
  parameter int SHORT_LEN = 16,
  parameter int LONG_LEN  = 64,
  parameter int SYM_LEN   = 64,
  parameter logic [ROM_W-1:0] SHORT_ROM = romPattern(3),
  parameter logic [ROM_W-1:0] LONG_ROM  = romPattern(5)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  asmStrobe_t             strobe,
  input  logic                   inValid,
  input  logic signed [IQ_W-1:0] inI,
  input  logic signed [IQ_W-1:0] inQ,
  output logic                   inReady,
  output logic                   bufFull,
  output logic signed [IQ_W-1:0] outI,
  output logic signed [IQ_W-1:0] outQ
);
  localparam int SH_AW = $clog2(SHORT_LEN);
  localparam int LG_AW = $clog2(LONG_LEN);
  localparam int PY_AW = $clog2(SYM_LEN);

  logic [SAMP_W-1:0] shortArr [SHORT_LEN];
  logic [SAMP_W-1:0] longArr  [LONG_LEN];
  logic [SAMP_W-1:0] payRam   [SYM_LEN];
  logic [PY_AW:0]    wrCnt;
  logic [SAMP_W-1:0] rdWord;

  for (genvar k = 0; k < SHORT_LEN; k++) begin : gShort
    assign shortArr[k] = SHORT_ROM[k*SAMP_W +: SAMP_W];
  end
  for (genvar k = 0; k < LONG_LEN; k++) begin : gLong
    assign longArr[k] = LONG_ROM[k*SAMP_W +: SAMP_W];
  end

  assign bufFull = (wrCnt == (PY_AW + 1)'(SYM_LEN));
  assign inReady = strobe.frameOn && !bufFull;

  always_ff @(posedge clk) begin
    if (!rstN) wrCnt <= '0;
    else if (strobe.frameStart || strobe.bufRelease) wrCnt <= '0;
    else if (inValid && inReady) wrCnt <= wrCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (inValid && inReady) payRam[wrCnt[PY_AW-1:0]] <= {inI, inQ};
  end

  always_comb begin
    unique case (strobe.src)
      SRC_LONG: rdWord = longArr[strobe.addr[LG_AW-1:0]];
      SRC_PAY:  rdWord = payRam[strobe.addr[PY_AW-1:0]];
      default:  rdWord = shortArr[strobe.addr[SH_AW-1:0]];
    endcase
  end

  assign outI = rdWord[SAMP_W-1:IQ_W];
  assign outQ = rdWord[IQ_W-1:0];
endmodule

// File: rtl/ofdm_frame_asm.sv
module ofdm_frame_asm
  import ofdm_asm_pkg::*;
#(
  parameter int SHORT_LEN   = 16,
  parameter int SHORT_REPS  = 10,
  parameter int LONG_LEN    = 64,
  parameter int LONG_CP     = 32,
  parameter int LONG_COPIES = 2,
  parameter int SYM_LEN     = 64,
  parameter int SYM_CP      = 16,
  parameter int NUM_SYMS    = 2,
  parameter logic [ROM_W-1:0] SHORT_ROM = romPattern(3),
  parameter logic [ROM_W-1:0] LONG_ROM  = romPattern(5)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic                   osEn,
  input  logic                   inValid,
  output logic                   inReady,
  input  logic signed [IQ_W-1:0] inI,
  input  logic signed [IQ_W-1:0] inQ,
  output logic                   outValid,
  input  logic                   outReady,
  output logic signed [IQ_W-1:0] outI,
  output logic signed [IQ_W-1:0] outQ,
  output logic                   outLast
);
  asmStrobe_t strobe;
  logic       bufFull;
  logic       frameBusy;

  assign frameBusy = strobe.frameOn;

  frame_ctrl #(
    .SHORT_LEN(SHORT_LEN), .SHORT_REPS(SHORT_REPS), .LONG_LEN(LONG_LEN),
    .LONG_CP(LONG_CP), .LONG_COPIES(LONG_COPIES), .SYM_LEN(SYM_LEN),
    .SYM_CP(SYM_CP), .NUM_SYMS(NUM_SYMS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .osEn(osEn), .bufFull(bufFull),
    .outReady(outReady), .strobe(strobe), .outValid(outValid), .outLast(outLast)
  );

  frame_dpath #(
    .SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN), .SYM_LEN(SYM_LEN),
    .SHORT_ROM(SHORT_ROM), .LONG_ROM(LONG_ROM)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inValid(inValid), .inI(inI),
    .inQ(inQ), .inReady(inReady), .bufFull(bufFull), .outI(outI), .outQ(outQ)
  );
endmodule

// File: rtl/frame_asm_chk.sv
module frame_asm_chk #(
  parameter int FRAME_LEN = 480
) (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic        osEn,
  input logic        busy,
  input logic        inReady,
  input logic        outValid,
  input logic        outReady,
  input logic [15:0] outI,
  input logic [15:0] outQ,
  input logic        outLast
);
  logic [10:0] cnt;
  logic        osLatch;
  logic        lastFire;

  assign lastFire = outValid && outReady && outLast;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= '0;
      osLatch <= 1'b0;
    end else begin
      if (start && !busy) osLatch <= osEn;
      if (!busy) cnt <= '0;
      else if (outValid && outReady) cnt <= cnt + 1'b1;
    end
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outI) && $stable(outQ) && $stable(outLast));

  assert_last_valid_R5: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);

  assert_frame_len_R6: assert property (@(posedge clk) disable iff (!rstN)
    lastFire |-> cnt == (osLatch ? 11'(2 * FRAME_LEN - 1) : 11'(FRAME_LEN - 1)));

  assert_idle_after_R5: assert property (@(posedge clk) disable iff (!rstN)
    lastFire |=> !busy);

  assert_busy_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    busy && !lastFire |=> busy);

  assert_in_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !inReady);

  assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !outValid);
endmodule

bind ofdm_frame_asm frame_asm_chk u_chk (
  .clk(clk), .rstN(rstN), .start(start), .osEn(osEn), .busy(frameBusy),
  .inReady(inReady), .outValid(outValid), .outReady(outReady),
  .outI(outI), .outQ(outQ), .outLast(outLast)
);

// File: tb/sim_ofdm_frame_asm.sv
module sim_ofdm_frame_asm;
  import ofdm_asm_pkg::*;

  function automatic logic [ROM_W-1:0] benchRom(input int seed);
    logic [ROM_W-1:0] v;
    v = '0;
    for (int k = 0; k < ROM_DEPTH; k++)
      v[k*32 +: 32] = {16'(k * 1000 + seed), 16'(-(k * 37 * seed) + 5)};
    return v;
  endfunction

  localparam logic [ROM_W-1:0] B_SHORT = benchRom(7);
  localparam logic [ROM_W-1:0] B_LONG  = benchRom(13);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, osEn = 1'b0, inValid = 1'b0, outReady = 1'b0;
  logic signed [15:0] inI = '0, inQ = '0;
  logic inReady, outValid, outLast;
  logic signed [15:0] outI, outQ;

  int checks = 0, fails = 0, cycles = 0;
  logic [31:0] payMem [0:127];

  always #2 clk = ~clk;

  ofdm_frame_asm #(.SHORT_ROM(B_SHORT), .LONG_ROM(B_LONG)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .osEn(osEn), .inValid(inValid),
    .inReady(inReady), .inI(inI), .inQ(inQ), .outValid(outValid),
    .outReady(outReady), .outI(outI), .outQ(outQ), .outLast(outLast)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expSample(input int n, input bit os);
    int m, p, s, q;
    m = os ? n / 2 : n;
    if (m < 160) return B_SHORT[(m % 16)*32 +: 32];
    if (m < 192) return B_LONG[(32 + m - 160)*32 +: 32];
    if (m < 320) return B_LONG[((m - 192) % 64)*32 +: 32];
    p = m - 320; s = p / 80; q = p % 80;
    if (q < 16) return payMem[s*64 + 48 + q];
    return payMem[s*64 + q - 16];
  endfunction

  function automatic string secName(input int n, input bit os);
    int m;
    m = os ? n / 2 : n;
    if (os) return "R6";
    if (m < 160) return "R2";
    if (m < 320) return "R3";
    return "R4";
  endfunction

  task automatic runFrame(input bit os, input int readyPct, input int inHold, input bit midStart);
    int outCnt = 0, pIdx = 0, cyc = 0, flen;
    bit prevStall = 0, r9Done = 0;
    logic [32:0] prevOut = '0;
    flen = os ? 960 : 480;
    for (int k = 0; k < 128; k++) payMem[k] = $urandom;
    @(negedge clk);
    start = 1'b1; osEn = os;
    @(negedge clk);
    start = 1'b0; osEn = 1'b0;
    while (outCnt < flen && cyc < 20000) begin
      outReady = (($urandom % 100) < readyPct);
      inValid  = (cyc >= inHold) && (pIdx < 128) && (($urandom % 100) < 70);
      {inI, inQ} = payMem[(pIdx < 128) ? pIdx : 0];
      start = midStart && (cyc == 50 || cyc == 400);
      #1;
      if (prevStall)
        check(outValid && ({outLast, outI, outQ} == prevOut), "R7",
              {outI, outQ}, prevOut[31:0]);
      if (!os && outCnt == 320 && pIdx < 64 && !r9Done) begin
        check(!outValid, "R9", {31'd0, outValid}, 32'd0);
        r9Done = 1;
      end
      if (outValid && outReady) begin
        check({outI, outQ} == expSample(outCnt, os), secName(outCnt, os),
              {outI, outQ}, expSample(outCnt, os));
        check(outLast == (outCnt == flen - 1), os ? "R6" : "R5",
              {31'd0, outLast}, {31'd0, outCnt == flen - 1});
        outCnt++;
      end
      prevStall = outValid && !outReady;
      prevOut   = {outLast, outI, outQ};
      if (inValid && inReady) pIdx++;
      cyc++;
      @(negedge clk);
    end
    start = 1'b0; inValid = 1'b0; outReady = 1'b1;
    check(cyc < 20000, "R5", cyc, 20000);
    check(pIdx == 128, "R4", pIdx, 128);
    repeat (4) @(negedge clk);
    check(!outValid && !inReady, "R8", {outValid, inReady}, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    check(!outValid && !outLast && !inReady, "R1", {outValid, outLast, inReady}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(!outValid && !outLast && !inReady, "R1", {outValid, outLast, inReady}, 0);
    runFrame(1'b0, 60, 0, 1'b1);
    runFrame(1'b1, 50, 0, 1'b1);
    runFrame(1'b0, 100, 400, 1'b0);
    runFrame(1'b1, 100, 10, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule